// File: doc/BRIEF.md
# Link Latency Meter

This block measures how many link-clock cycles a sample takes to cross a converter receive path. A converter asserts a timestamp marker next to one of its samples. The marker travels through the serial link along with the data and comes back as a set least significant bit in one of the received sample lanes. The meter starts counting on the rising edge of the marker. It stops on the first cycle in which the received stream is valid and any lane carries a set LSB. It then holds the count for reading.

Repeatability across resets and power cycles matters as much as the latency value itself. For that reason the block can be re-armed for each run. It stores one completed result as a reference, and it judges every later result against that reference within a small tolerance. A run that never sees the returning marker saturates the counter and is flagged as a timeout. Lane count, sample width, counter width and tolerance are parameters.

Top module: `lat_meter`

## Requirements
- R1: After reset, `count_o` is 0, and `done_o`, `timeout_o`, `ref_valid_o`, `pass_o` and `fail_o` are all 0. The meter stays idle until its first arm.
- R2: Counting starts only on a 0-to-1 transition of `marker_i` while the meter is armed. Marker edges before the first arm, and marker edges during a running measurement, have no effect.
- R3: If the marker rise is sampled on clock edge T and the stop event on edge T+D (D ≥ 1), then `count_o` holds D. The count is registered and shows at that same edge T+D.
- R4: A stop event is `rx_valid_i` high together with bit 0 of any lane being 1. Lane i occupies `samples_i[i*SAMPLE_W +: SAMPLE_W]`, so its LSB is bit i*SAMPLE_W. A set LSB while `rx_valid_i` is low is ignored. Set bits other than lane LSBs are also ignored.
- R5: After a stop event, `done_o` is 1. `count_o` and the flags then stay unchanged, whatever the marker and stream do, until the next arm.
- R6: With no stop event, the count saturates at 2^CNT_W-1 on edge T+2^CNT_W-1. At that point `timeout_o` is 1 and `done_o` stays 0.
- R7: A one-cycle `arm_i` clears `count_o`, `done_o`, `timeout_o`, `pass_o` and `fail_o` on the next edge, and arms a new measurement. It does not clear the stored reference.
- R8: After a `cap_ref_i` strobe, the next completed measurement (done, not timeout) is stored as the reference. `ref_valid_o` is 1 one edge after `done_o` rises, and that run gives no verdict.
- R9: When a reference is held, a later completed measurement sets `pass_o` if |count − reference| ≤ TOL (default 2), and sets `fail_o` otherwise. The flag appears one edge after `done_o` rises.
- R10: A timeout while a reference is held sets `fail_o` one edge after `timeout_o` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst | input | 1 | Synchronous active-high reset |
| arm_i | input | 1 | One-cycle strobe that clears the result and arms a measurement |
| cap_ref_i | input | 1 | One-cycle strobe: store the next completed result as the reference |
| marker_i | input | 1 | Timestamp marker from the converter, synchronous to clk |
| rx_valid_i | input | 1 | Received sample stream is valid (link established) |
| samples_i | input | LANES*SAMPLE_W | Parallel received samples, lane i at [i*SAMPLE_W +: SAMPLE_W] |
| count_o | output | CNT_W | Measured latency in link clocks |
| done_o | output | 1 | Measurement completed by a stop event |
| timeout_o | output | 1 | Counter saturated without a stop event |
| ref_valid_o | output | 1 | A reference count is stored |
| pass_o | output | 1 | Last result within tolerance of the reference |
| fail_o | output | 1 | Last result outside tolerance, or timed out |

## Verification
The meter is run many times with known, randomly chosen marker-to-LSB delays. The returning bit is placed in a random lane with random filler in the upper bits. Each run is judged against a reference taken at a fixed delay, so the pass/fail boundary is probed exactly at ±TOL and one step beyond it. Decoy patterns are mixed in to show that only a valid, LSB-located bit ends a count and that a mid-run marker edge cannot restart it: set non-LSB bits, set LSBs while the stream is invalid, and a second marker pulse during counting. One run left without a stop event shows saturation and the timeout verdict. A late reference capture shows that a fresh reference replaces the old one.

// File: rtl/llm_pkg.sv
package llm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARMED,
    ST_COUNT,
    ST_DONE,
    ST_TIMEOUT
  } meas_st_t;
endpackage

// File: rtl/llm_events.sv
// Start-edge and stop-event detection for the latency meter.
module llm_events #(
  parameter int LANES    = 4,
  parameter int SAMPLE_W = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      marker_i,
  input  logic                      rx_valid_i,
  input  logic [LANES*SAMPLE_W-1:0] samples_i,
  output logic                      start_o,
  output logic                      stop_o
);
  localparam int BUS_W = LANES * SAMPLE_W;

  logic             marker_q;
  logic [LANES-1:0] lane_lsb;

  always_ff @(posedge clk) begin
    if (rst) marker_q <= 1'b0;
    else     marker_q <= marker_i;
  end

  assign start_o = marker_i & ~marker_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_lsb[g] = samples_i[g*SAMPLE_W];
  end

  assign stop_o = rx_valid_i & (|lane_lsb);

  // R4: a stop is never flagged while the stream is invalid
  a_r4_stop_needs_valid: assert property (@(posedge clk) disable iff (rst)
    stop_o |-> rx_valid_i);
  // R2: a start is a rising edge of the marker
  a_r2_start_is_edge: assert property (@(posedge clk) disable iff (rst)
    start_o |=> !start_o);

  initial begin
    if (BUS_W < 1) $error("bus width must be positive");
  end
endmodule

// File: rtl/llm_span_counter.sv
// Measurement state machine with a saturating cycle counter.
module llm_span_counter
  import llm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm_i,
  input  logic             start_i,
  input  logic             stop_i,
  output logic [CNT_W-1:0] count_o,
  output logic             done_o,
  output logic             timeout_o,
  output logic             fin_o
);
  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_MAX - 1'b1;

  meas_st_t         st;
  logic [CNT_W-1:0] cnt;
  logic             fin_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_IDLE;
      cnt   <= '0;
      fin_q <= 1'b0;
    end else begin
      fin_q <= 1'b0;
      if (arm_i) begin
        st  <= ST_ARMED;
        cnt <= '0;
      end else begin
        unique case (st)
          ST_ARMED: begin
            if (start_i) begin
              st  <= ST_COUNT;
              cnt <= '0;
            end
          end
          ST_COUNT: begin
            if (stop_i) begin
              cnt   <= cnt + 1'b1;
              st    <= ST_DONE;
              fin_q <= 1'b1;
            end else if (cnt == CNT_LAST) begin
              cnt   <= CNT_MAX;
              st    <= ST_TIMEOUT;
              fin_q <= 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign count_o   = cnt;
  assign done_o    = (st == ST_DONE);
  assign timeout_o = (st == ST_TIMEOUT);
  assign fin_o     = fin_q;

  // R5: result frozen while done and not re-armed
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (done_o && !arm_i) |=> ($stable(count_o) && done_o));
  // R6: timeout only at the saturated value
  a_r6_saturated: assert property (@(posedge clk) disable iff (rst)
    timeout_o |-> (count_o == CNT_MAX));
  // R7: arm clears the result
  a_r7_arm_clears: assert property (@(posedge clk) disable iff (rst)
    arm_i |=> (count_o == '0 && !done_o && !timeout_o));
  // R3: done only rises after a detected stop event
  a_r3_done_from_stop: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> $past(stop_i));
endmodule

// File: rtl/llm_judge.sv
// Reference capture and drift verdict.
module llm_judge #(
  parameter int CNT_W = 16,
  parameter int TOL   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm_i,
  input  logic             cap_ref_i,
  input  logic             fin_i,
  input  logic             timeout_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             ref_valid_o,
  output logic             pass_o,
  output logic             fail_o
);
  localparam logic [CNT_W-1:0] TOL_V = CNT_W'(TOL);

  logic [CNT_W-1:0] ref_q;
  logic             ref_valid_q;
  logic             pending_q;
  logic             pass_q;
  logic             fail_q;
  logic [CNT_W-1:0] drift;

  assign drift = (count_i >= ref_q) ? (count_i - ref_q) : (ref_q - count_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q       <= '0;
      ref_valid_q <= 1'b0;
      pending_q   <= 1'b0;
      pass_q      <= 1'b0;
      fail_q      <= 1'b0;
    end else begin
      if (arm_i) begin
        pass_q <= 1'b0;
        fail_q <= 1'b0;
      end else if (fin_i) begin
        if (timeout_i) begin
          if (ref_valid_q && !pending_q) fail_q <= 1'b1;
        end else if (pending_q) begin
          ref_q       <= count_i;
          ref_valid_q <= 1'b1;
          pending_q   <= 1'b0;
        end else if (ref_valid_q) begin
          pass_q <= (drift <= TOL_V);
          fail_q <= (drift >  TOL_V);
        end
      end
      if (cap_ref_i) pending_q <= 1'b1;
    end
  end

  assign ref_valid_o = ref_valid_q;
  assign pass_o      = pass_q;
  assign fail_o      = fail_q;

  // R9: never both verdicts
  a_r9_one_verdict: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pass_o, fail_o}));
  // R7: arm clears verdicts
  a_r7_verdict_clear: assert property (@(posedge clk) disable iff (rst)
    arm_i |=> (!pass_o && !fail_o));
  // R8: once a reference exists it stays
  a_r8_ref_sticky: assert property (@(posedge clk) disable iff (rst)
    ref_valid_o |=> ref_valid_o);
endmodule

// File: rtl/lat_meter.sv
// Top: timestamp-based link latency meter.
module lat_meter #(
  parameter int LANES    = 4,
  parameter int SAMPLE_W = 16,
  parameter int CNT_W    = 16,
  parameter int TOL      = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      arm_i,
  input  logic                      cap_ref_i,
  input  logic                      marker_i,
  input  logic                      rx_valid_i,
  input  logic [LANES*SAMPLE_W-1:0] samples_i,
  output logic [CNT_W-1:0]          count_o,
  output logic                      done_o,
  output logic                      timeout_o,
  output logic                      ref_valid_o,
  output logic                      pass_o,
  output logic                      fail_o
);
  logic start_w;
  logic stop_w;
  logic fin_w;

  llm_events #(.LANES(LANES), .SAMPLE_W(SAMPLE_W)) u_events (
    .clk        (clk),
    .rst        (rst),
    .marker_i   (marker_i),
    .rx_valid_i (rx_valid_i),
    .samples_i  (samples_i),
    .start_o    (start_w),
    .stop_o     (stop_w)
  );

  llm_span_counter #(.CNT_W(CNT_W)) u_counter (
    .clk       (clk),
    .rst       (rst),
    .arm_i     (arm_i),
    .start_i   (start_w),
    .stop_i    (stop_w),
    .count_o   (count_o),
    .done_o    (done_o),
    .timeout_o (timeout_o),
    .fin_o     (fin_w)
  );

  llm_judge #(.CNT_W(CNT_W), .TOL(TOL)) u_judge (
    .clk         (clk),
    .rst         (rst),
    .arm_i       (arm_i),
    .cap_ref_i   (cap_ref_i),
    .fin_i       (fin_w),
    .timeout_i   (timeout_o),
    .count_i     (count_o),
    .ref_valid_o (ref_valid_o),
    .pass_o      (pass_o),
    .fail_o      (fail_o)
  );

  // R1: idle flags low right after reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (!done_o && !timeout_o && !pass_o && !fail_o));
endmodule

// File: tb/lat_meter_tb.sv
module lat_meter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LANES      = 4;
  localparam int SAMPLE_W   = 16;
  localparam int CNT_W      = 16;
  localparam int TOL        = 2;
  localparam int BUS_W      = LANES * SAMPLE_W;
  localparam int CMAX       = (1 << CNT_W) - 1;
  localparam int REF_D      = 40;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             arm_i = 1'b0;
  logic             cap_ref_i = 1'b0;
  logic             marker_i = 1'b0;
  logic             rx_valid_i = 1'b0;
  logic [BUS_W-1:0] samples_i = '0;
  logic [CNT_W-1:0] count_o;
  logic             done_o, timeout_o, ref_valid_o, pass_o, fail_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lat_meter #(.LANES(LANES), .SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W), .TOL(TOL)) dut_i (
    .clk(clk), .rst(rst), .arm_i(arm_i), .cap_ref_i(cap_ref_i),
    .marker_i(marker_i), .rx_valid_i(rx_valid_i), .samples_i(samples_i),
    .count_o(count_o), .done_o(done_o), .timeout_o(timeout_o),
    .ref_valid_o(ref_valid_o), .pass_o(pass_o), .fail_o(fail_o)
  );

  function automatic logic [BUS_W-1:0] lsb_mask();
    logic [BUS_W-1:0] m = '0;
    for (int i = 0; i < LANES; i++) m[i*SAMPLE_W] = 1'b1;
    return m;
  endfunction

  function automatic logic [BUS_W-1:0] filler();
    logic [BUS_W-1:0] v;
    for (int i = 0; i < BUS_W; i += 32) v[i +: 32] = $urandom();
    return v & ~lsb_mask();
  endfunction

  function automatic bit exp_pass(int d, int r);
    int diff = (d >= r) ? d - r : r - d;
    return diff <= TOL;
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic arm(bit cap);
    @(negedge clk);
    arm_i = 1'b1; cap_ref_i = cap;
    @(negedge clk);
    arm_i = 1'b0; cap_ref_i = 1'b0;
  endtask

  // decoy: 0 none, 1 non-LSB bits, 2 LSB with stream invalid
  task automatic run(int d, int lane, int decoy, bit retrig);
    @(negedge clk);
    marker_i = 1'b1; rx_valid_i = 1'b1; samples_i = filler();
    for (int k = 1; k <= d; k++) begin
      @(negedge clk);
      marker_i   = retrig && (k == d/2);
      rx_valid_i = 1'b1;
      samples_i  = filler();
      if (k == d) samples_i[lane*SAMPLE_W] = 1'b1;
      else if (decoy == 1 && k == d-3) samples_i = ~lsb_mask();
      else if (decoy == 2 && k == d-3) begin
        samples_i = lsb_mask(); rx_valid_i = 1'b0;
      end
    end
    @(negedge clk);
    samples_i = filler(); marker_i = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    check("R1 count", count_o, 0);
    check("R1 done", done_o, 0);
    check("R1 timeout", timeout_o, 0);
    check("R1 ref_valid", ref_valid_o, 0);
    check("R1 verdict", pass_o | fail_o, 0);
    // R2: marker before first arm ignored
    run(7, 1, 0, 0);
    check("R2 pre-arm done", done_o, 0);
    check("R2 pre-arm count", count_o, 0);

    // R8: reference capture
    arm(1'b1);
    run(REF_D, 2, 0, 0);
    check("R3 ref count", count_o, REF_D);
    check("R5 ref done", done_o, 1);
    check("R8 ref_valid", ref_valid_o, 1);
    check("R8 no verdict", pass_o | fail_o, 0);

    // R9 boundaries
    for (int off = -5; off <= 5; off++) begin
      arm(1'b0);
      run(REF_D + off, (off + 5) % LANES, 0, 0);
      check("R3 count", count_o, REF_D + off);
      check("R9 pass", pass_o, exp_pass(REF_D + off, REF_D));
      check("R9 fail", fail_o, !exp_pass(REF_D + off, REF_D));
    end

    // random runs with decoys and retriggers
    for (int n = 0; n < 30; n++) begin
      int d = REF_D - 6 + $urandom_range(12);
      int ln = $urandom_range(LANES-1);
      int dc = $urandom_range(2);
      bit rt = $urandom_range(1);
      arm(1'b0);
      run(d, ln, dc, rt);
      check("R4 R2 decoy count", count_o, d);
      check("R9 rand verdict", pass_o, exp_pass(d, REF_D));
    end

    // R5: result stable after further markers and stops
    rx_valid_i = 1'b1; samples_i = lsb_mask(); marker_i = 1'b1;
    @(negedge clk); marker_i = 1'b0;
    repeat (3) @(negedge clk);
    samples_i = '0;
    check("R5 stable done", done_o, 1);

    // R7: arm clears
    arm(1'b0);
    check("R7 count", count_o, 0);
    check("R7 done", done_o, 0);
    check("R7 verdict", pass_o | fail_o, 0);
    check("R7 ref kept", ref_valid_o, 1);

    // R8 recapture
    arm(1'b1);
    run(100, 3, 0, 0);
    check("R8 new ref no verdict", pass_o | fail_o, 0);
    arm(1'b0);
    run(102, 0, 0, 0);
    check("R8 new ref pass", pass_o, 1);
    arm(1'b0);
    run(REF_D, 0, 0, 0);
    check("R8 old value now fails", fail_o, 1);

    // R6 R10: timeout
    arm(1'b0);
    @(negedge clk);
    marker_i = 1'b1; rx_valid_i = 1'b1; samples_i = '0;
    @(negedge clk);
    marker_i = 1'b0;
    repeat (CMAX + 1) @(negedge clk);
    check("R6 saturated count", count_o, CMAX);
    check("R6 timeout", timeout_o, 1);
    check("R6 not done", done_o, 0);
    check("R10 timeout fail", fail_o, 1);

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule